// File: doc/BRIEF.md
# I2C Target Byte-Memory Emulator

This block is an I2C target that looks, from the bus, like a small byte-addressed memory with a self-advancing access pointer. It oversamples the SCL and SDA lines with the system clock, recognises START and STOP conditions, and compares the first byte after a START with a programmable 7-bit own address. When the address matches, it acknowledges and then serves the transfer.

In the write direction, the first data byte loads the pointer. Later bytes are stored at the pointer, and the pointer steps forward with wraparound at the memory size. In the read direction, every byte sent is the memory byte at the pointer, again followed by a step forward. A watch window, given as a start address and a length, flags every memory write that lands inside it with a one-cycle notification pulse that carries the address and the byte. An enable input turns the emulation off: data bytes are then refused and reads return zeros.

The SDA pin is open-drain: `sda_oe_o` high means the block pulls SDA low. It never stretches SCL.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset `sda_oe_o` is 0, the pointer is 0x00, every memory byte reads 0x00 and the own address is 0x01.
- R2: The block acknowledges (drives SDA low in the ninth bit) only a first byte after START whose bits [7:1] equal the own address; bit 0 set means read. On a mismatch it releases SDA and ignores the bus until the next START.
- R3: A one-cycle `own_addr_we_i` loads `own_addr_i` as the new own address, and the old address is then refused.
- R4: The first data byte after a matched write-direction address loads the pointer, writes no memory and raises no notification.
- R5: Each further received byte is acknowledged and written at the pointer, and the pointer then advances by one modulo 256 (0xFF is followed by 0x00).
- R6: Each byte sent to the master, MSB first, is the memory byte at the pointer, and the pointer then advances by one modulo 256.
- R7: A master NAK after a sent byte ends the transmission: SDA stays released until the next START, and the pointer has advanced only for the bytes actually sent.
- R8: A write address with one pointer byte, followed by a repeated START and a read address, returns data starting at the loaded pointer.
- R9: With `watch_en_i` set, a memory write at an address in [watch_start_i, watch_start_i + watch_size_i - 1] gives a one-cycle `wnotify_o` pulse with that address and byte. Writes outside this range give none.
- R10: A watch window with watch_start_i + watch_size_i greater than 256 is rejected and gives no notification. A window that ends exactly at 0xFF is accepted.
- R11: With `emu_en_i` low, matched addresses are still acknowledged, but data bytes are NAKed, the memory and the pointer are left unchanged, and bytes read by the master are 0x00.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| sda_oe_o | output | 1 | High to pull SDA low |
| emu_en_i | input | 1 | Emulation enable |
| own_addr_we_i | input | 1 | Load strobe for the own address |
| own_addr_i | input | 7 | New own address |
| watch_en_i | input | 1 | Watch window enable |
| watch_start_i | input | 8 | First address of the watch window |
| watch_size_i | input | 9 | Number of addresses in the watch window |
| wnotify_o | output | 1 | One-cycle pulse for a write inside the window |
| wnotify_addr_o | output | 8 | Address of the notified write |
| wnotify_data_o | output | 8 | Byte of the notified write |

## Verification
A table of pointer and data pairs drives a write transaction and then a combined pointer-load-and-read for each pair. Across the table, every bit pattern and both ends of the address range come back, which separates correct storage from shifted or inverted bytes. Directed sequences then look at the cases the table cannot tell apart. A pointer-only write against a pre-filled location shows whether the first byte is taken as a pointer or as data. Runs that cross 0xFF show the wraparound. A wrong address, a changed own address and a disabled unit show what is refused. Watch windows that sit inside, at the upper edge and beyond the memory show which writes raise a notification. A master NAK followed by extra clocks shows the SDA release and the single pointer step.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int BYTE_W = 8;
    localparam int OWN_W  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_RX,
        ST_ACK_R,
        ST_TX,
        ST_TX_ACK
    } eng_st_e;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] prev_o
);

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d, prev_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[l]};
            prev_d  = chain_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign sync_o[l] = chain_q[STAGES-1];
        assign prev_o[l] = prev_q;
    end

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              emu_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              addr_wr,
    output logic              addr_rd,
    output logic              bus_stop,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_req
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  bits;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              mack;
        logic              oe;
    } eng_t;

    eng_t r_q, r_d;

    logic scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

    always_comb begin
        r_d      = r_q;
        addr_wr  = 1'b0;
        addr_rd  = 1'b0;
        bus_stop = 1'b0;
        rx_valid = 1'b0;
        tx_req   = 1'b0;
        if (start_c) begin
            r_d.st   = ST_ADDR;
            r_d.bits = '0;
            r_d.oe   = 1'b0;
        end else if (stop_c) begin
            r_d.st   = ST_IDLE;
            r_d.oe   = 1'b0;
            bus_stop = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.bits = r_q.bits + 1'b1;
                    end else if (scl_fall && r_q.bits == FULL) begin
                        r_d.bits = '0;
                        if (r_q.sh[BYTE_W-1:1] == own_addr) begin
                            r_d.oe  = 1'b1;
                            r_d.rw  = r_q.sh[0];
                            r_d.st  = ST_ACK_A;
                            addr_wr = ~r_q.sh[0];
                            addr_rd = r_q.sh[0];
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (scl_fall) begin
                        r_d.bits = '0;
                        if (r_q.rw) begin
                            tx_req   = 1'b1;
                            r_d.sh   = tx_byte;
                            r_d.oe   = ~tx_byte[BYTE_W-1];
                            r_d.st   = ST_TX;
                        end else begin
                            r_d.oe   = 1'b0;
                            r_d.st   = ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.bits = r_q.bits + 1'b1;
                    end else if (scl_fall && r_q.bits == FULL) begin
                        rx_valid = 1'b1;
                        r_d.oe   = emu_en;
                        r_d.bits = '0;
                        r_d.st   = ST_ACK_R;
                    end
                end
                ST_ACK_R: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.bits = r_q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.bits == FULL) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_TX_ACK;
                        end else begin
                            r_d.sh = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe = ~r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        r_d.bits = '0;
                        if (r_q.mack) begin
                            tx_req = 1'b1;
                            r_d.sh = tx_byte;
                            r_d.oe = ~tx_byte[BYTE_W-1];
                            r_d.st = ST_TX;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, bits: '0, sh: '0, rw: 1'b0, mack: 1'b0, oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe  = r_q.oe;
    assign rx_byte = r_q.sh;

    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe) |-> !$past(scl_s));

    // R2
    addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr || addr_rd) |=> sda_oe);

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store
    import i2c_rf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu_en,
    input  logic              addr_wr,
    input  logic              addr_rd,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_req,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              watch_en,
    input  logic [ADDR_W-1:0] watch_start,
    input  logic [ADDR_W:0]   watch_size,
    output logic              wn_valid,
    output logic [ADDR_W-1:0] wn_addr,
    output logic [BYTE_W-1:0] wn_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SUM_W = ADDR_W + 2;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              load;
        logic              wn_v;
        logic [ADDR_W-1:0] wn_a;
        logic [BYTE_W-1:0] wn_d;
    } st_t;

    st_t r_q, r_d;
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic              mem_we;
    logic [SUM_W-1:0]  win_end;
    logic              win_ok, win_hit;

    always_comb begin
        win_end = SUM_W'(watch_start) + SUM_W'(watch_size);
        win_ok  = win_end <= SUM_W'(DEPTH);
        win_hit = watch_en && win_ok
                  && (SUM_W'(r_q.ptr) >= SUM_W'(watch_start))
                  && (SUM_W'(r_q.ptr) < win_end);
    end

    always_comb begin
        r_d      = r_q;
        r_d.wn_v = 1'b0;
        mem_we   = 1'b0;
        if (addr_wr) begin
            r_d.load = 1'b1;
        end
        if (addr_rd || bus_stop) begin
            r_d.load = 1'b0;
        end
        if (rx_valid && emu_en) begin
            if (r_q.load) begin
                r_d.ptr  = ADDR_W'(rx_byte);
                r_d.load = 1'b0;
            end else begin
                mem_we  = 1'b1;
                r_d.ptr = r_q.ptr + 1'b1;
                if (win_hit) begin
                    r_d.wn_v = 1'b1;
                    r_d.wn_a = r_q.ptr;
                    r_d.wn_d = rx_byte;
                end
            end
        end
        if (tx_req && emu_en) begin
            r_d.ptr = r_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (mem_we) begin
            mem_q[r_q.ptr] <= rx_byte;
        end
    end

    assign tx_byte  = emu_en ? mem_q[r_q.ptr] : '0;
    assign wn_valid = r_q.wn_v;
    assign wn_addr  = r_q.wn_a;
    assign wn_data  = r_q.wn_d;

    // R5
    wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && emu_en && !r_q.load) |=> (r_q.ptr == ADDR_W'($past(r_q.ptr) + 1'b1)));

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && emu_en && r_q.load) |=> (r_q.ptr == ADDR_W'($past(rx_byte)) && !wn_valid));

    // R6
    rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && emu_en) |=> (r_q.ptr == ADDR_W'($past(r_q.ptr) + 1'b1)));

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_en && (rx_valid || tx_req)) |=> $stable(r_q.ptr));

    // R9
    notify_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wn_valid |=> !wn_valid);

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_rf_pkg::*;
#(
    parameter int               ADDR_W         = 8,
    parameter int               SYNC_STAGES    = 2,
    parameter logic [OWN_W-1:0] RESET_OWN_ADDR = 7'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              emu_en_i,
    input  logic              own_addr_we_i,
    input  logic [OWN_W-1:0]  own_addr_i,
    input  logic              watch_en_i,
    input  logic [ADDR_W-1:0] watch_start_i,
    input  logic [ADDR_W:0]   watch_size_i,
    output logic              wnotify_o,
    output logic [ADDR_W-1:0] wnotify_addr_o,
    output logic [BYTE_W-1:0] wnotify_data_o
);

    logic [1:0]        line_s, line_p;
    logic [OWN_W-1:0]  own_d, own_q;
    logic              addr_wr, addr_rd, bus_stop, rx_valid, tx_req;
    logic [BYTE_W-1:0] rx_byte, tx_byte;

    i2c_rf_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_s),
        .prev_o  (line_p)
    );

    always_comb begin
        own_d = own_addr_we_i ? own_addr_i : own_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= RESET_OWN_ADDR;
        end else begin
            own_q <= own_d;
        end
    end

    i2c_rf_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[1]),
        .scl_p    (line_p[1]),
        .sda_s    (line_s[0]),
        .sda_p    (line_p[0]),
        .own_addr (own_q),
        .emu_en   (emu_en_i),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe_o),
        .addr_wr  (addr_wr),
        .addr_rd  (addr_rd),
        .bus_stop (bus_stop),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_req   (tx_req)
    );

    i2c_rf_store #(
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .emu_en      (emu_en_i),
        .addr_wr     (addr_wr),
        .addr_rd     (addr_rd),
        .bus_stop    (bus_stop),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_req      (tx_req),
        .tx_byte     (tx_byte),
        .watch_en    (watch_en_i),
        .watch_start (watch_start_i),
        .watch_size  (watch_size_i),
        .wn_valid    (wnotify_o),
        .wn_addr     (wnotify_addr_o),
        .wn_data     (wnotify_data_o)
    );

    // R3
    own_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own_addr_we_i |=> (own_q == $past(own_addr_i)));

endmodule

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 150000;

    localparam logic [15:0] VEC [8] = '{
        16'h00A5, 16'h103C, 16'h7F01, 16'hFF80,
        16'h42FF, 16'h4300, 16'hC85A, 16'h01E7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       emu_en = 1'b1;
    logic       own_we = 1'b0;
    logic [6:0] own_val = 7'h00;
    logic       w_en = 1'b0;
    logic [7:0] w_start = 8'h00;
    logic [8:0] w_size = 9'h000;
    logic       sda_oe;
    logic       wn;
    logic [7:0] wn_a, wn_d;
    wire        sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regfile_target dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_m),
        .sda_i          (sda_bus),
        .sda_oe_o       (sda_oe),
        .emu_en_i       (emu_en),
        .own_addr_we_i  (own_we),
        .own_addr_i     (own_val),
        .watch_en_i     (w_en),
        .watch_start_i  (w_start),
        .watch_size_i   (w_size),
        .wnotify_o      (wn),
        .wnotify_addr_o (wn_a),
        .wnotify_data_o (wn_d)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    int         wn_cnt = 0;
    logic [7:0] wn_la = 8'h00, wn_ld = 8'h00;
    int         r12_viol = 0;
    logic       prev_oe = 1'b0;
    logic [7:0] mdl_mem [256];
    logic [7:0] mdl_ptr = 8'h00;
    logic [6:0] dev = 7'h01;
    logic [7:0] wbuf [8];

    always @(posedge clk) begin
        if (wn) begin
            wn_cnt = wn_cnt + 1;
            wn_la  = wn_a;
            wn_ld  = wn_d;
        end
    end

    always @(negedge clk) begin
        if (sda_oe !== prev_oe && scl_m) r12_viol = r12_viol + 1;
        prev_oe = sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic send_addr(input string tag, input logic rd, input logic exp_ack);
        logic ak;
        bus_start();
        put_byte({dev, rd}, ak);
        chk(tag, ak, exp_ack);
    endtask

    task automatic write_txn(input string tag, input logic [7:0] ptr, input int n);
        logic ak;
        send_addr(tag, 1'b0, 1'b1);
        put_byte(ptr, ak);
        chk(tag, ak, emu_en);
        if (emu_en) mdl_ptr = ptr;
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], ak);
            chk(tag, ak, emu_en);
            if (emu_en) begin
                mdl_mem[mdl_ptr] = wbuf[i];
                mdl_ptr = mdl_ptr + 8'h01;
            end
        end
        bus_stop();
    endtask

    task automatic read_txn(input string tag, input logic use_ptr, input logic [7:0] ptr, input int n);
        logic ak;
        logic [7:0] v;
        if (use_ptr) begin
            send_addr(tag, 1'b0, 1'b1);
            put_byte(ptr, ak);
            chk(tag, ak, emu_en);
            if (emu_en) mdl_ptr = ptr;
        end
        send_addr(tag, 1'b1, 1'b1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, v);
            chk(tag, v, emu_en ? mdl_mem[mdl_ptr] : 8'h00);
            if (emu_en) mdl_ptr = mdl_ptr + 8'h01;
        end
        bus_stop();
    endtask

    task automatic set_own(input logic [6:0] a);
        @(negedge clk); own_val = a; own_we = 1'b1;
        @(negedge clk); own_we = 1'b0;
        dev = a;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        logic ak;
        logic b;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", sda_oe, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 oe after reset", sda_oe, 1'b0);
        // R1: default address 0x01, pointer 0, memory cleared
        read_txn("R1", 1'b0, 8'h00, 2);
        read_txn("R1", 1'b1, 8'hD0, 1);

        // Table: write one byte, then combined read (R5, R8)
        for (int i = 0; i < 8; i++) begin
            wbuf[0] = VEC[i][7:0];
            write_txn("R5", VEC[i][15:8], 1);
            read_txn("R8", 1'b1, VEC[i][15:8], 1);
        end

        // R2: wrong address refused, following bytes ignored
        dev = 7'h05;
        send_addr("R2", 1'b0, 1'b0);
        put_byte(8'hEE, ak); chk("R2 data after mismatch", ak, 1'b0);
        put_byte(8'h12, ak); chk("R2 data after mismatch", ak, 1'b0);
        bus_stop();
        dev = 7'h01;
        read_txn("R2", 1'b0, 8'h00, 1);
        read_txn("R2", 1'b1, 8'hEE, 1);

        // R3: programmable own address
        set_own(7'h5A);
        dev = 7'h01;
        send_addr("R3 old addr", 1'b0, 1'b0);
        bus_stop();
        dev = 7'h5A;
        read_txn("R3", 1'b1, 8'h42, 1);
        set_own(7'h01);

        // R5 and R6: wraparound at 0xFF
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_txn("R5", 8'hFE, 3);
        read_txn("R6", 1'b1, 8'hFE, 3);
        chk("R5 wrap to 0x00", mdl_mem[0], 8'h33);

        // R4: pointer-only write
        wbuf[0] = 8'hC1; wbuf[1] = 8'hD4;
        write_txn("R4", 8'h98, 2);
        write_txn("R4", 8'h99, 0);
        read_txn("R4", 1'b0, 8'h00, 1);
        read_txn("R4", 1'b1, 8'h9A, 1);

        // R7: master NAK ends transmission
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
        write_txn("R7", 8'h50, 2);
        send_addr("R7", 1'b0, 1'b1);
        put_byte(8'h50, ak);
        send_addr("R7", 1'b1, 1'b1);
        get_byte(1'b0, v);
        chk("R7 byte", v, 8'hA1);
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            chk("R7 released", b, 1'b1);
        end
        bus_stop();
        mdl_ptr = 8'h51;
        read_txn("R7", 1'b0, 8'h00, 1);

        // R9: watch window 0x60..0x63
        w_en = 1'b1; w_start = 8'h60; w_size = 9'd4;
        base = wn_cnt;
        for (int i = 0; i < 6; i++) wbuf[i] = 8'(i + 1);
        write_txn("R9", 8'h5F, 6);
        chk("R9 count", wn_cnt - base, 4);
        chk("R9 addr", wn_la, 8'h63);
        chk("R9 data", wn_ld, 8'h05);
        wbuf[0] = 8'hAB;
        write_txn("R9", 8'h60, 1);
        chk("R9 count", wn_cnt - base, 5);
        chk("R9 addr", wn_la, 8'h60);
        chk("R9 data", wn_ld, 8'hAB);

        // R10: oversized window rejected, edge window accepted
        w_start = 8'hFE; w_size = 9'd3;
        base = wn_cnt;
        wbuf[0] = 8'h09; wbuf[1] = 8'h09;
        write_txn("R10", 8'hFE, 2);
        chk("R10 rejected", wn_cnt - base, 0);
        w_start = 8'hFC; w_size = 9'd4;
        wbuf[0] = 8'h77;
        write_txn("R10", 8'hFF, 1);
        wbuf[0] = 8'h01;
        write_txn("R10", 8'hFB, 1);
        chk("R10 edge count", wn_cnt - base, 1);
        chk("R10 edge addr", wn_la, 8'hFF);
        chk("R10 edge data", wn_ld, 8'h77);
        w_en = 1'b0;

        // R11: disabled unit
        wbuf[0] = 8'h3E;
        write_txn("R11", 8'h70, 1);
        write_txn("R11", 8'h70, 0);
        emu_en = 1'b0;
        wbuf[0] = 8'h44;
        write_txn("R11", 8'h55, 1);
        read_txn("R11", 1'b0, 8'h00, 2);
        emu_en = 1'b1;
        read_txn("R11", 1'b0, 8'h00, 1);
        chk("R11 mem kept", mdl_mem[8'h70], 8'h3E);

        chk("R12 oe only with SCL low", r12_viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule